// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter with Victim Holding Buffer

This system-side block keeps a copy of the tags of one processor's direct-mapped external cache. The copy uses a reduced coherence state. Other memory users snoop the copy instead of the processor. Under a write-invalidate protocol, a snoop that needs exclusive ownership and hits a tracked line makes the block drop that line and issue an invalidate for the processor's cache.

A read miss can displace a dirty line. The read and the resulting writeback can then finish in either order. While they are outstanding, the displaced line's address and state sit in a small fully associative holding buffer with one entry per processor writeback slot. That buffer acts as extra duplicate-tag entries: every snoop searches it together with the main tag array. A hit in it marks a line whose data still sits in the writeback path.

An entry is freed only once both the read and the writeback for its cache index have been reported. When all entries are busy, a new dirty-victim miss is held off. A build-time option changes how pending indices are handled. In that mode, buffer lookup is not used for snoops. Instead, snoops to an index with a pending entry are stalled until the entry frees.

Top module: `dtsf_snoop_filter`

## Requirements
- R1: After reset every tracked line is invalid, the holding buffer is empty, both request ports are ready and no snoop response or invalidate is driven.
- R2: States use a 2-bit code: 0 invalid, 1 shared-clean, 2 owned-dirty. An accepted miss with `req_excl_i`=1 is recorded as owned-dirty, and one with `req_excl_i`=0 as shared-clean. A snoop accepted on one clock edge has its result valid from the next edge.
- R3: An address is `{tag, index}`, with the index in the low IDX_W bits. The tag array is direct-mapped, so a newer miss at an index replaces the older line, and snoops to the older address then miss.
- R4: An exclusive snoop that hits produces `inv_valid_o` with the snooped address in the response cycle, and afterwards that address misses. A non-exclusive snoop changes no state.
- R5: A miss with `req_dirty_i`=1 places the line previously tracked at that index into the holding buffer with its previous state. Snoops to it then hit with `snp_from_tb_o`=1.
- R6: A holding-buffer entry stays valid until both the read completion and the writeback completion for its index have arrived, in either order.
- R7: With every buffer entry busy, `req_ready_o` is low for a dirty-victim miss until an entry frees. A miss without a dirty victim is still accepted.
- R8: When the tag array and the holding buffer both hit on an address, the response carries the buffer's state with `snp_from_tb_o`=1.
- R9: An exclusive snoop that hits a buffer entry issues an invalidate and marks the entry invalid. Later snoops to that address miss, but the entry stays occupied until both completions arrive.
- R10: With STALL_ON_PENDING=1, `snp_ready_o` is low while a buffer entry is pending at the snooped index, and responses come from the tag array only.
- R11: A snoop that misses returns hit 0, state 0 and no invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor miss request valid |
| req_ready_o | output | 1 | Miss request accepted when high |
| req_addr_i | input | IDX_W+TAG_W | Line address being filled |
| req_excl_i | input | 1 | Miss is a read-for-ownership |
| req_dirty_i | input | 1 | Miss displaces a dirty line |
| rd_done_i | input | 1 | Read for an index completed |
| rd_done_idx_i | input | IDX_W | Index of completed read |
| wb_done_i | input | 1 | Writeback for an index completed |
| wb_done_idx_i | input | IDX_W | Index of completed writeback |
| snp_valid_i | input | 1 | Snoop request valid |
| snp_ready_o | output | 1 | Snoop accepted when high |
| snp_addr_i | input | IDX_W+TAG_W | Snooped line address |
| snp_excl_i | input | 1 | Snoop needs exclusive ownership |
| snp_rsp_valid_o | output | 1 | Snoop response valid |
| snp_hit_o | output | 1 | Snooped line is tracked |
| snp_state_o | output | 2 | Reduced state of snooped line |
| snp_from_tb_o | output | 1 | Hit came from holding buffer |
| inv_valid_o | output | 1 | Invalidate to processor cache |
| inv_addr_o | output | IDX_W+TAG_W | Address to invalidate |

## Verification
Snoops are swept over every address of a 4-index, 4-tag build after reset, after filling, and after replacement. This separates index decoding, tag matching and the state recorded for ordinary versus ownership fills.

Dirty-victim misses are then completed in read-first and in writeback-first order. Those runs distinguish early release from correct two-sided release. Full-buffer back-pressure, an exclusive snoop on a buffered line, and an address held in both structures at once test stall behaviour, invalidation in the buffer and lookup priority.

A second instance built in stall mode receives the same stimulus. This shows the rejected snoops and the array-only responses.

// File: rtl/dtsf_pkg.sv
package dtsf_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_O = 2'd2
  } dstate_e;
endpackage

// File: rtl/dtsf_tag_array.sv
module dtsf_tag_array
  import dtsf_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  output logic [TAG_W-1:0] lk_tag_o,
  output dstate_e          lk_st_o,
  input  logic [IDX_W-1:0] vic_idx_i,
  output logic [TAG_W-1:0] vic_tag_o,
  output dstate_e          vic_st_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  dstate_e          wr_st_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [DEPTH];
  dstate_e          st_q  [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  // fill write wins over a same-cycle invalidate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_I;
    end else begin
      if (inv_en_i) st_q[inv_idx_i] <= ST_I;
      if (wr_en_i)  st_q[wr_idx_i]  <= wr_st_i;
    end
  end

  assign lk_tag_o  = tag_q[lk_idx_i];
  assign lk_st_o   = st_q[lk_idx_i];
  assign vic_tag_o = tag_q[vic_idx_i];
  assign vic_st_o  = st_q[vic_idx_i];
endmodule

// File: rtl/dtsf_victim_buf.sv
module dtsf_victim_buf
  import dtsf_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_en_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  dstate_e           alloc_st_i,
  output logic              full_o,
  input  logic              rd_done_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wb_done_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output dstate_e           lk_st_o,
  input  logic              kill_en_i,
  input  logic [IDX_W-1:0]  busy_idx_i,
  output logic              busy_o
);
  logic              v_q    [ENTRIES];
  logic              r_q    [ENTRIES];
  logic              w_q    [ENTRIES];
  logic [ADDR_W-1:0] addr_q [ENTRIES];
  dstate_e           st_q   [ENTRIES];

  logic [ENTRIES-1:0] vld, free, alloc_sel, hit_vec, lk_sel, busy_vec;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) vld[e] = v_q[e];
  end

  assign free      = ~vld;
  assign alloc_sel = free & (~free + ENTRIES'(1));
  assign lk_sel    = hit_vec & (~hit_vec + ENTRIES'(1));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic rd_clr, wb_clr;
    assign rd_clr      = rd_done_i && (addr_q[e][IDX_W-1:0] == rd_idx_i);
    assign wb_clr      = wb_done_i && (addr_q[e][IDX_W-1:0] == wb_idx_i);
    assign hit_vec[e]  = v_q[e] && (st_q[e] != ST_I) && (addr_q[e] == lk_addr_i);
    assign busy_vec[e] = v_q[e] && (addr_q[e][IDX_W-1:0] == busy_idx_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[e]    <= 1'b0;
        r_q[e]    <= 1'b0;
        w_q[e]    <= 1'b0;
        addr_q[e] <= '0;
        st_q[e]   <= ST_I;
      end else if (alloc_en_i && alloc_sel[e]) begin
        v_q[e]    <= 1'b1;
        r_q[e]    <= 1'b1;
        w_q[e]    <= 1'b1;
        addr_q[e] <= alloc_addr_i;
        st_q[e]   <= alloc_st_i;
      end else if (v_q[e]) begin
        r_q[e] <= r_q[e] && !rd_clr;
        w_q[e] <= w_q[e] && !wb_clr;
        // release only when both halves are done
        if ((!r_q[e] || rd_clr) && (!w_q[e] || wb_clr)) v_q[e] <= 1'b0;
        if (kill_en_i && lk_sel[e]) st_q[e] <= ST_I;
      end
    end
  end

  always_comb begin
    lk_st_o = ST_I;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_sel[e]) lk_st_o = st_q[e];
    end
  end

  assign lk_hit_o = |hit_vec;
  assign full_o   = &vld;
  assign busy_o   = |busy_vec;
endmodule

// File: rtl/dtsf_snoop_filter.sv
module dtsf_snoop_filter
  import dtsf_pkg::*;
#(
  parameter int IDX_W            = 6,
  parameter int TAG_W            = 20,
  parameter int WB_N             = 4,
  parameter bit STALL_ON_PENDING = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [IDX_W+TAG_W-1:0] req_addr_i,
  input  logic                   req_excl_i,
  input  logic                   req_dirty_i,
  input  logic                   rd_done_i,
  input  logic [IDX_W-1:0]       rd_done_idx_i,
  input  logic                   wb_done_i,
  input  logic [IDX_W-1:0]       wb_done_idx_i,
  input  logic                   snp_valid_i,
  output logic                   snp_ready_o,
  input  logic [IDX_W+TAG_W-1:0] snp_addr_i,
  input  logic                   snp_excl_i,
  output logic                   snp_rsp_valid_o,
  output logic                   snp_hit_o,
  output logic [1:0]             snp_state_o,
  output logic                   snp_from_tb_o,
  output logic                   inv_valid_o,
  output logic [IDX_W+TAG_W-1:0] inv_addr_o
);
  localparam int ADDR_W = IDX_W + TAG_W;

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag, dt_tag, vic_tag;
  dstate_e          dt_st, vic_st, tb_st, hit_st, st_q;
  logic             tb_full, tb_raw_hit, tb_busy, tb_hit, dt_hit;
  logic             req_fire, snp_fire, snp_hit;

  assign req_idx = req_addr_i[IDX_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  assign req_ready_o = !(req_dirty_i && tb_full);
  assign req_fire    = req_valid_i && req_ready_o;
  // stall mode: hold snoops to a pending index instead of searching the buffer
  assign snp_ready_o = !(STALL_ON_PENDING && tb_busy);
  assign snp_fire    = snp_valid_i && snp_ready_o;

  dtsf_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tag_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (snp_idx),
    .lk_tag_o  (dt_tag),
    .lk_st_o   (dt_st),
    .vic_idx_i (req_idx),
    .vic_tag_o (vic_tag),
    .vic_st_o  (vic_st),
    .wr_en_i   (req_fire),
    .wr_idx_i  (req_idx),
    .wr_tag_i  (req_tag),
    .wr_st_i   (req_excl_i ? ST_O : ST_S),
    .inv_en_i  (snp_fire && snp_excl_i && dt_hit),
    .inv_idx_i (snp_idx)
  );

  dtsf_victim_buf #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRIES(WB_N)) i_victim_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (req_fire && req_dirty_i),
    .alloc_addr_i ({vic_tag, req_idx}),
    .alloc_st_i   (vic_st),
    .full_o       (tb_full),
    .rd_done_i    (rd_done_i),
    .rd_idx_i     (rd_done_idx_i),
    .wb_done_i    (wb_done_i),
    .wb_idx_i     (wb_done_idx_i),
    .lk_addr_i    (snp_addr_i),
    .lk_hit_o     (tb_raw_hit),
    .lk_st_o      (tb_st),
    .kill_en_i    (snp_fire && snp_excl_i && tb_hit),
    .busy_idx_i   (snp_idx),
    .busy_o       (tb_busy)
  );

  assign tb_hit  = tb_raw_hit && !STALL_ON_PENDING;
  assign dt_hit  = (dt_st != ST_I) && (dt_tag == snp_tag);
  assign snp_hit = tb_hit || dt_hit;
  assign hit_st  = tb_hit ? tb_st : (dt_hit ? dt_st : ST_I);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snp_rsp_valid_o <= 1'b0;
      snp_hit_o       <= 1'b0;
      st_q            <= ST_I;
      snp_from_tb_o   <= 1'b0;
      inv_valid_o     <= 1'b0;
      inv_addr_o      <= '0;
    end else begin
      snp_rsp_valid_o <= snp_fire;
      snp_hit_o       <= snp_fire && snp_hit;
      st_q            <= snp_fire ? hit_st : ST_I;
      snp_from_tb_o   <= snp_fire && tb_hit;
      inv_valid_o     <= snp_fire && snp_excl_i && snp_hit;
      if (snp_fire) inv_addr_o <= snp_addr_i;
    end
  end

  assign snp_state_o = st_q;
endmodule

// File: rtl/dtsf_snoop_filter_chk.sv
module dtsf_snoop_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_dirty_i,
  input logic       req_ready_o,
  input logic       snp_valid_i,
  input logic       snp_ready_o,
  input logic       snp_rsp_valid_o,
  input logic       snp_hit_o,
  input logic [1:0] snp_state_o,
  input logic       snp_from_tb_o,
  input logic       inv_valid_o
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_ready_o |=> snp_rsp_valid_o); // R2
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_rsp_valid_o |-> $past(snp_valid_i && snp_ready_o)); // R2
  AST_INV_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> snp_rsp_valid_o && snp_hit_o); // R4
  AST_HIT_STATE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> snp_state_o != 2'd0); // R11
  AST_MISS_STATE_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_rsp_valid_o && !snp_hit_o |-> snp_state_o == 2'd0 && !inv_valid_o); // R11
  AST_TB_SRC_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_from_tb_o |-> snp_hit_o); // R8
  AST_CLEAN_NEVER_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_o |-> req_dirty_i); // R7
endmodule

bind dtsf_snoop_filter dtsf_snoop_filter_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_dirty_i     (req_dirty_i),
  .req_ready_o     (req_ready_o),
  .snp_valid_i     (snp_valid_i),
  .snp_ready_o     (snp_ready_o),
  .snp_rsp_valid_o (snp_rsp_valid_o),
  .snp_hit_o       (snp_hit_o),
  .snp_state_o     (snp_state_o),
  .snp_from_tb_o   (snp_from_tb_o),
  .inv_valid_o     (inv_valid_o)
);

// File: tb/test_dtsf_snoop_filter.sv
module test_dtsf_snoop_filter;
  localparam int IW = 2, TW = 2, NE = 2, NI = 4, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_excl = 0, req_dirty = 0;
  logic [AW-1:0] req_addr = '0;
  logic rd_done = 0, wb_done = 0;
  logic [IW-1:0] rd_idx = '0, wb_idx = '0;
  logic snp_valid = 0, snp_excl = 0;
  logic [AW-1:0] snp_addr = '0;

  logic a_req_ready, a_snp_ready, a_rsp, a_hit, a_tb, a_inv;
  logic [1:0] a_st;
  logic [AW-1:0] a_inv_addr;
  logic s_req_ready, s_snp_ready, s_rsp, s_hit, s_tb, s_inv;
  logic [1:0] s_st;
  logic [AW-1:0] s_inv_addr;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  int m_tag [NI], m_st [NI], s_stm [NI];
  bit tb_v [NE], tb_r [NE], tb_w [NE];
  int tb_a [NE], tb_s [NE];

  always #10 clk = ~clk;

  dtsf_snoop_filter #(.IDX_W(IW), .TAG_W(TW), .WB_N(NE), .STALL_ON_PENDING(1'b0)) i_dtsf_snoop_filter (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(a_req_ready),
    .req_addr_i(req_addr), .req_excl_i(req_excl), .req_dirty_i(req_dirty),
    .rd_done_i(rd_done), .rd_done_idx_i(rd_idx), .wb_done_i(wb_done), .wb_done_idx_i(wb_idx),
    .snp_valid_i(snp_valid), .snp_ready_o(a_snp_ready), .snp_addr_i(snp_addr), .snp_excl_i(snp_excl),
    .snp_rsp_valid_o(a_rsp), .snp_hit_o(a_hit), .snp_state_o(a_st), .snp_from_tb_o(a_tb),
    .inv_valid_o(a_inv), .inv_addr_o(a_inv_addr));

  dtsf_snoop_filter #(.IDX_W(IW), .TAG_W(TW), .WB_N(NE), .STALL_ON_PENDING(1'b1)) i_dtsf_snoop_filter_stall (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(s_req_ready),
    .req_addr_i(req_addr), .req_excl_i(req_excl), .req_dirty_i(req_dirty),
    .rd_done_i(rd_done), .rd_done_idx_i(rd_idx), .wb_done_i(wb_done), .wb_done_idx_i(wb_idx),
    .snp_valid_i(snp_valid), .snp_ready_o(s_snp_ready), .snp_addr_i(snp_addr), .snp_excl_i(snp_excl),
    .snp_rsp_valid_o(s_rsp), .snp_hit_o(s_hit), .snp_state_o(s_st), .snp_from_tb_o(s_tb),
    .inv_valid_o(s_inv), .inv_addr_o(s_inv_addr));

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit tb_full();
    bit f = 1;
    for (int k = 0; k < NE; k++) f &= tb_v[k];
    return f;
  endfunction

  function automatic bit pend(int idx);
    bit p = 0;
    for (int k = 0; k < NE; k++) if (tb_v[k] && (tb_a[k] % NI) == idx) p = 1;
    return p;
  endfunction

  task automatic req(int addr, bit ex, bit dr, string rq);
    int idx = addr % NI;
    @(negedge clk);
    req_addr = AW'(addr); req_excl = ex; req_dirty = dr; req_valid = 1;
    #1;
    chk(rq, "req_ready", int'(a_req_ready), int'(!(dr && tb_full())));
    chk("R10", "stall req_ready", int'(s_req_ready), int'(!(dr && tb_full())));
    @(negedge clk);
    req_valid = 0;
    if (dr) begin
      for (int k = 0; k < NE; k++) begin
        if (!tb_v[k]) begin
          tb_v[k] = 1; tb_r[k] = 1; tb_w[k] = 1;
          tb_a[k] = m_tag[idx] * NI + idx; tb_s[k] = m_st[idx];
          break;
        end
      end
    end
    m_tag[idx] = addr / NI;
    m_st[idx]  = ex ? 2 : 1;
    s_stm[idx] = ex ? 2 : 1;
  endtask

  task automatic model_done(bit rd, bit wb, int idx);
    for (int k = 0; k < NE; k++) begin
      if (tb_v[k] && (tb_a[k] % NI) == idx) begin
        if (rd) tb_r[k] = 0;
        if (wb) tb_w[k] = 0;
        if (!tb_r[k] && !tb_w[k]) tb_v[k] = 0;
      end
    end
  endtask

  task automatic done(bit rd, bit wb, int idx);
    @(negedge clk);
    rd_done = rd; wb_done = wb; rd_idx = IW'(idx); wb_idx = IW'(idx);
    @(negedge clk);
    rd_done = 0; wb_done = 0;
    model_done(rd, wb, idx);
  endtask

  task automatic snp(int addr, bit ex, string rq);
    int idx = addr % NI, tag = addr / NI;
    int tk = -1;
    bit dh, hit, ok, sh;
    int st;
    for (int k = NE - 1; k >= 0; k--)
      if (tb_v[k] && tb_a[k] == addr && tb_s[k] != 0) tk = k;
    dh  = (m_st[idx] != 0) && (m_tag[idx] == tag);
    hit = dh || (tk >= 0);
    st  = (tk >= 0) ? tb_s[tk] : (dh ? m_st[idx] : 0);
    ok  = !pend(idx);
    sh  = (s_stm[idx] != 0) && (m_tag[idx] == tag);
    @(negedge clk);
    snp_addr = AW'(addr); snp_excl = ex; snp_valid = 1;
    #1;
    chk(rq, "snp_ready", int'(a_snp_ready), 1);
    chk("R10", "stall snp_ready", int'(s_snp_ready), int'(ok));
    @(negedge clk);
    snp_valid = 0;
    chk(rq, "rsp_valid", int'(a_rsp), 1);
    chk(rq, "hit", int'(a_hit), int'(hit));
    chk(rq, "state", int'(a_st), st);
    chk(rq, "from_tb", int'(a_tb), int'(tk >= 0));
    chk(rq, "inv_valid", int'(a_inv), int'(ex && hit));
    if (ex && hit) chk(rq, "inv_addr", int'(a_inv_addr), addr);
    chk("R10", "stall rsp_valid", int'(s_rsp), int'(ok));
    if (ok) begin
      chk("R10", "stall hit", int'(s_hit), int'(sh));
      chk("R10", "stall state", int'(s_st), sh ? s_stm[idx] : 0);
      chk("R10", "stall from_tb", int'(s_tb), 0);
      if (ex && sh) s_stm[idx] = 0;
    end
    if (ex) begin
      if (dh) m_st[idx] = 0;
      if (tk >= 0) tb_s[tk] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NI; i++) begin m_tag[i] = 0; m_st[i] = 0; s_stm[i] = 0; end
    for (int k = 0; k < NE; k++) begin tb_v[k] = 0; tb_r[k] = 0; tb_w[k] = 0; tb_a[k] = 0; tb_s[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    req_dirty = 1;
    #1;
    // R1 reset state
    chk("R1", "rsp_valid", int'(a_rsp), 0);
    chk("R1", "inv_valid", int'(a_inv), 0);
    chk("R1", "req_ready", int'(a_req_ready), 1);
    chk("R1", "snp_ready", int'(s_snp_ready), 1);
    req_dirty = 0;
    for (int a = 0; a < 16; a++) snp(a, 0, "R1");

    // R2 fills: tag = idx^1, ownership fill on odd indices
    for (int i = 0; i < NI; i++) req(((i ^ 1) * NI) + i, i[0], 0, "R2");
    for (int a = 0; a < 16; a++) snp(a, 0, "R2");
    for (int a = 0; a < 16; a++) snp(a, 0, "R11");

    // R3 replacement at index 0
    req(8, 0, 0, "R3");
    snp(4, 0, "R3");
    snp(8, 0, "R3");

    // R4 exclusive snoop
    snp(1, 1, "R4");
    snp(1, 0, "R4");

    // R5 dirty victim at index 3 (victim addr 11)
    req(3, 0, 1, "R5");
    snp(11, 0, "R5");
    snp(3, 0, "R5");

    // R6 read first, then writeback
    done(1, 0, 3);
    snp(11, 0, "R6");
    done(0, 1, 3);
    snp(11, 0, "R6");
    // R6 writeback first, then read (victim addr 14)
    req(2, 1, 1, "R6");
    done(0, 1, 2);
    snp(14, 0, "R6");
    done(1, 0, 2);
    snp(14, 0, "R6");

    // R7 fill the buffer
    req(4, 0, 1, "R7");
    req(6, 0, 1, "R7");
    req(13, 0, 0, "R7");

    // R9 exclusive snoop on buffered line 2
    snp(2, 1, "R9");
    snp(2, 0, "R9");

    // R7 back-pressure and release
    @(negedge clk);
    req_addr = 4'd7; req_excl = 0; req_dirty = 1; req_valid = 1;
    #1;
    chk("R7", "req_ready full", int'(a_req_ready), 0);
    @(negedge clk);
    chk("R9", "req_ready held", int'(a_req_ready), 0);
    rd_done = 1; wb_done = 1; rd_idx = 2'd0; wb_idx = 2'd0;
    @(negedge clk);
    rd_done = 0; wb_done = 0;
    model_done(1, 1, 0);
    #1;
    chk("R7", "req_ready freed", int'(a_req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < NE; k++) begin
      if (!tb_v[k]) begin
        tb_v[k] = 1; tb_r[k] = 1; tb_w[k] = 1;
        tb_a[k] = m_tag[3] * NI + 3; tb_s[k] = m_st[3];
        break;
      end
    end
    m_tag[3] = 1; m_st[3] = 1; s_stm[3] = 1;
    snp(7, 0, "R7");
    done(1, 1, 2);
    snp(2, 0, "R9");

    // R8 victim 3 held in buffer while array refills it as owned
    req(3, 1, 0, "R8");
    snp(3, 0, "R8");
    done(1, 1, 3);
    snp(3, 0, "R8");

    for (int a = 0; a < 16; a++) snp(a, 0, "R3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule